// File: doc/BRIEF.md
# Inter-Core Set/Clear Mailbox Bank

This block holds a bank of 32-bit mailboxes used by processor cores to signal one another. Each core owns a fixed group of mailboxes (four per core, four cores by default, sixteen in all). Mailbox number `core*4 + j` belongs to core `core`, where `j` (0 to 3) selects the mailbox inside that core's group.

Software reaches the bank through a 32-bit word register port. The port has a separate write channel and read channel, each with its own byte address. Writes never overwrite a mailbox. A write into the set window ORs the written word into the addressed mailbox. A write into the clear window removes every bit that is one in the written word. Reads of the clear window return the mailbox content. Reads anywhere else return zero.

Every mailbox drives a pending flag that is high while its content is nonzero. The flags leave the block as a flat vector, four bits per core. Masking and routing of these flags to interrupt lines is left to a separate router.

Top module: `mbx_bank`

## Requirements
- R1: After reset every mailbox is zero, every bit of `pend` is low, and `rd_data` is zero.
- R2: A write to a 4-byte aligned address 0x80 + 4*n (n = 0..15) ORs `wr_data` into mailbox n. The result is visible from the clock edge that takes the write.
- R3: A write to a 4-byte aligned address 0xC0 + 4*n clears each bit of mailbox n that is one in `wr_data`. All other bits of that mailbox keep their value.
- R4: A read with `rd_en` high at a 4-byte aligned address 0xC0 + 4*n puts the content of mailbox n on `rd_data` one clock later. Reading does not change the content.
- R5: `rd_data` is zero one clock after a read of the set window (0x80 to 0xBF), of any address below 0x80, or of any address that is not 4-byte aligned. It is also zero one clock after any cycle in which `rd_en` is low.
- R6: Bit `core*4 + j` of `pend` is high exactly while mailbox `core*4 + j` is nonzero. The flag follows the same clock edge that changes the content.
- R7: A write to an address that is not 4-byte aligned, or to an address below 0x80, changes no mailbox.
- R8: A set or clear write changes only the addressed mailbox. The other fifteen keep their content.
- R9: When a read and a write reach the same mailbox in one cycle, the read returns the content held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data, used as a set mask or a clear mask |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, registered, valid one cycle after `rd_en` |
| pend | output | 16 | Nonzero flag per mailbox, bit core*4+j |

## Verification
Directed cases come first:
- Set masks with overlapping bits tell an OR apart from an overwrite.
- Partial clear masks tell a bitwise clear apart from a full wipe.
- Single-bit patterns, applied one mailbox at a time, show that no write spills into a neighbour.
- Reads of the set window, of low addresses and of misaligned addresses separate correct window decoding from aliasing.
- Same-cycle read and clear of one mailbox shows whether the read returns the old or the new content.

After the directed cases, random sequences of set, clear, read and stray accesses run against a bench model. The pending vector is compared after every operation.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // True when byte address a falls in [base, base + span).
   function automatic logic in_window(input logic [31:0] a,
                                      input logic [31:0] base,
                                      input logic [31:0] span);
      return (a >= base) && (a < base + span);
   endfunction

   // Word-aligned check on the two low address bits.
   function automatic logic word_aligned(input logic [1:0] low);
      return low == 2'b00;
   endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_BOX  = 16,
   parameter int unsigned SET_BASE = 32'h80,
   parameter int unsigned CLR_BASE = 32'hC0,
   localparam int unsigned IDX_W   = $clog2(NUM_BOX),
   localparam int unsigned SPAN    = NUM_BOX * 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              set_hit,
   output logic              clr_hit,
   output logic [IDX_W-1:0]  idx
);
   import mbx_pkg::*;

   logic [31:0] addr32;
   logic        aligned;

   always_comb begin
      addr32  = 32'(addr);
      aligned = word_aligned(addr[1:0]);
      set_hit = aligned && in_window(addr32, SET_BASE, SPAN);
      clr_hit = aligned && in_window(addr32, CLR_BASE, SPAN);
      if (set_hit) idx = IDX_W'((addr32 - SET_BASE) >> 2);
      else         idx = IDX_W'((addr32 - CLR_BASE) >> 2);
   end

   // An address never hits both windows at once.
   p_one_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_hit, clr_hit}));

   // A misaligned address hits neither window.
   p_misaligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[1:0] != 2'b00) |-> (!set_hit && !clr_hit));

endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] box,
   output logic              busy
);
   logic [DATA_W-1:0] set_m;
   logic [DATA_W-1:0] clr_m;
   logic [DATA_W-1:0] box_nx;

   always_comb begin
      set_m  = set_en ? mask : '0;
      clr_m  = clr_en ? mask : '0;
      // The clear is applied after the set.
      box_nx = (box | set_m) & ~clr_m;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                box <= '0;
      else if (set_en || clr_en) box <= box_nx;
   end

   assign busy = |box;

   p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en) |=> ((box & $past(mask)) == $past(mask)));

   p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en) |=> ((box & $past(box)) == $past(box)));

   p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((box & $past(mask)) == '0));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(box));

   p_pend_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(clr_en));

endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_BOX = 16,
   localparam int unsigned IDX_W  = $clog2(NUM_BOX)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_en,
   input  logic                            hit,
   input  logic [IDX_W-1:0]                idx,
   input  logic [NUM_BOX-1:0][DATA_W-1:0]  boxes,
   output logic [DATA_W-1:0]               rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rd_data <= '0;
      else if (rd_en && hit) rd_data <= boxes[idx];
      else                   rd_data <= '0;
   end

   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0));

   p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |=> (rd_data == '0));

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned PER_CORE  = 4,
   parameter int unsigned SET_BASE  = 32'h80,
   parameter int unsigned CLR_BASE  = 32'hC0,
   localparam int unsigned NUM_BOX  = NUM_CORES * PER_CORE,
   localparam int unsigned IDX_W    = $clog2(NUM_BOX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic [NUM_BOX-1:0] pend
);
   localparam int unsigned SPAN = NUM_BOX * 4;

   if (NUM_BOX < 2) begin : g_bad_count
      $error("mbx_bank: at least two mailboxes are required");
   end
   if ((SET_BASE % 4) != 0 || (CLR_BASE % 4) != 0) begin : g_bad_align
      $error("mbx_bank: window bases must be word aligned");
   end
   if (SET_BASE + SPAN > CLR_BASE) begin : g_bad_overlap
      $error("mbx_bank: set window overlaps clear window");
   end
   if (CLR_BASE + SPAN > (1 << ADDR_W)) begin : g_bad_range
      $error("mbx_bank: clear window exceeds address space");
   end

   logic             w_set, w_clr, r_set, r_clr;
   logic [IDX_W-1:0] w_idx, r_idx;
   logic [NUM_BOX-1:0][DATA_W-1:0] boxes;

   mbx_decode #(.ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX),
                .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)) u_wdec (
      .clk(clk), .rst_n(rst_n), .addr(wr_addr),
      .set_hit(w_set), .clr_hit(w_clr), .idx(w_idx));

   mbx_decode #(.ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX),
                .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)) u_rdec (
      .clk(clk), .rst_n(rst_n), .addr(rd_addr),
      .set_hit(r_set), .clr_hit(r_clr), .idx(r_idx));

   for (genvar n = 0; n < NUM_BOX; n++) begin : g_box
      logic sel;
      assign sel = wr_en && (w_idx == IDX_W'(n));
      mbx_cell #(.DATA_W(DATA_W)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .set_en(sel && w_set), .clr_en(sel && w_clr),
         .mask(wr_data), .box(boxes[n]), .busy(pend[n]));
   end

   mbx_rdmux #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(r_clr && !r_set),
      .idx(r_idx), .boxes(boxes), .rd_data(rd_data));

   // Stray writes leave every pending flag unchanged.
   p_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (!w_set && !w_clr)) |=> $stable(pend));

   // A set write can only raise flags, never lower one.
   p_set_no_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && w_set) |=> (($past(pend) & ~pend) == '0));

endmodule

// File: tb/mbx_bank_bench.sv
`timescale 1ns/1ps
module mbx_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [15:0] pend;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] m [16];

   always #2.5 clk = ~clk;

   mbx_bank u_mbx_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .pend(pend));

   function automatic logic [31:0] model_read(input logic [7:0] a);
      if (a[1:0] == 2'b00 && a >= 8'hC0) return m[a[5:2]];
      return 32'h0;
   endfunction

   function automatic logic [15:0] model_pend();
      logic [15:0] p;
      for (int i = 0; i < 16; i++) p[i] = (m[i] != 32'h0);
      return p;
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      if (a[1:0] == 2'b00 && a >= 8'h80) begin
         if (a < 8'hC0) m[a[5:2]] = m[a[5:2]] | d;
         else           m[a[5:2]] = m[a[5:2]] & ~d;
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd(input string req, input logic [7:0] a);
      logic [31:0] e;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      e = model_read(a);
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, rd_data, e);
   endtask

   task automatic chk_pend(input string req);
      chk(req, {16'h0, pend}, {16'h0, model_pend()});
   endtask

   task automatic chk_all(input string req);
      for (int i = 0; i < 16; i++) rd(req, 8'hC0 + 8'(4 * i));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) m[i] = 32'h0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 pend", {16'h0, pend}, 32'h0);
      chk("R1 rd_data", rd_data, 32'h0);
      chk_all("R1 readback");

      // R2: overlapping sets accumulate
      wr(8'h84, 32'h0000_00F0);
      wr(8'h84, 32'h0000_0F0F);
      rd("R2 or accumulate", 8'hC4);
      chk_pend("R6 pend after set");

      // R3: partial clear
      wr(8'hC4, 32'h0000_0101);
      rd("R3 partial clear", 8'hC4);
      wr(8'hC4, 32'hFFFF_FFFF);
      rd("R3 full clear", 8'hC4);
      chk_pend("R6 pend after clear");

      // R8: single bit into each mailbox, check no spill
      for (int i = 0; i < 16; i++) wr(8'h80 + 8'(4 * i), 32'h1 << i);
      chk_all("R8 isolation");
      chk_pend("R6 all pending");

      // R5: reads outside the clear window
      rd("R5 set window read", 8'h84);
      rd("R5 low address read", 8'h10);
      rd("R5 misaligned read", 8'hC2);
      @(negedge clk);
      chk("R5 idle rd_data", rd_data, 32'h0);

      // R7: stray writes change nothing
      wr(8'h81, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'hC3, 32'hFFFF_FFFF);
      chk_all("R7 stray write");
      chk_pend("R7 pend unchanged");

      // R9: read and clear of one mailbox in the same cycle
      wr(8'h88, 32'hA5A5_0000);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'hC8; wr_data = 32'hFFFF_FFFF;
      rd_en = 1'b1; rd_addr = 8'hC8;
      begin
         logic [31:0] old_v;
         old_v = m[2];
         @(negedge clk);
         wr_en = 1'b0; rd_en = 1'b0;
         model_write(8'hC8, 32'hFFFF_FFFF);
         chk("R9 read before write", rd_data, old_v);
      end
      rd("R9 content after clear", 8'hC8);
      chk_pend("R6 pend after same-cycle clear");

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int unsigned op;
         logic [31:0] d;
         logic [7:0]  a;
         op = $urandom % 5;
         d  = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
         a  = 8'(4 * ($urandom % 16));
         case (op)
            0: wr(8'h80 + a, d);
            1: wr(8'hC0 + a, d);
            2: rd("R4 random read", 8'hC0 + a);
            3: wr(8'($urandom), d);
            default: rd("R5 random stray read", 8'($urandom));
         endcase
         chk_pend("R6 random pend");
      end
      chk_all("R2 R3 final readback");

      finish_run();
   end
endmodule